// File: doc/BRIEF.md
# Serial-Load ARX Vector Mixer

This block takes two vectors of four 16-bit words, X and Y, and folds them into one four-word result Z. It works on each vector separately. For every output word of a side, it adds three of the four input words to a fixed 16-bit constant and rotates the sum left by a fixed amount. The four rotated words of a side are then combined through three-term XOR patterns. At the end, the mixed X word and the mixed Y word in each position are added, and the sums are placed in a permuted output order.

The core favours small area over speed. A start pulse opens a loading window. Eight words then arrive one at a time on a 16-bit port with a valid strobe, in the order X0, X1, X2, X3, Y0, Y1, Y2, Y3, and are stored locally under a write counter. A read counter then steps both sides through one sum-and-rotate equation per cycle, with the two sides running at the same time. One cycle forms the XOR combinations and a further cycle forms the final sums. A done flag then marks the four Z words as valid and holds them until the next start.

Top module: `arx_mix_core`

## Requirements
- R1: A synchronous active-high reset returns the core to idle, with busy and done both low.
- R2: After a start, the core stores only words presented with in_valid high. The first eight such words are X0..X3 and then Y0..Y3. Cycles with in_valid low store nothing and do not advance the load.
- R3: in_valid and in_word have no effect while the core is idle, computing, or showing a result.
- R4: A start seen while busy is high is ignored, and the load or computation in progress carries on unchanged.
- R5: busy rises on the clock edge that takes a start. Busy falls, and done rises, on the sixth clock edge after the edge that stored the eighth word. Busy and done are never high together.
- R6: On the X side, every addition wraps modulo 2^16. A=rotl1(0xF0E8+X0+X1+X2), B=rotl4(0xE4E2+X0+X1+X3), C=rotl9(0xE1D8+X0+X2+X3), D=rotl11(0xD4D2+X1+X2+X3). The combined words are P0=A^B^D, P1=A^B^C, P2=B^C^D and P3=A^C^D.
- R7: On the Y side, every addition wraps modulo 2^16. E=rotl2(0xD1CC+Y0+Y2+Y3), F=rotl5(0xCAC9+Y1+Y2+Y3), G=rotl7(0xC6C5+Y0+Y1+Y2), H=rotl13(0xC3B8+Y0+Y1+Y3). The combined words are Q0=F^G^H, Q1=E^G^H, Q2=E^F^H and Q3=E^F^G.
- R8: While done is high, the outputs are z3=P0+Q0, z0=P1+Q1, z1=P2+Q2 and z2=P3+Q3, each modulo 2^16.
- R9: done and the Z words hold steady until a start arrives. That start clears done on the same edge and begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new load when the core is idle or showing a result |
| in_valid | input | 1 | Marks in_word as a word to store |
| in_word | input | 16 | Serial input word |
| busy | output | 1 | High while loading or computing |
| done | output | 1 | High while z0..z3 hold a valid result |
| z0 | output | 16 | Result word 0 |
| z1 | output | 16 | Result word 1 |
| z2 | output | 16 | Result word 2 |
| z3 | output | 16 | Result word 3 |

## Verification
The hardest case to reach from the ports is a load broken up by idle strobes, with a stray start arriving in the middle. Here the write counter must hold its value across the gaps and ignore the start, yet the result must still appear exactly six edges after the eighth stored word. The stimulus builds such loads on purpose: it inserts gap cycles between words and raises start part-way through. It also drives in_valid with junk words while the core is idle, computing, and holding a result. The behavioural model, a queue of stored words with a countdown, then has to agree with the outputs on every clock. Vectors with one side all zero isolate the X and Y formulas, and all-ones vectors exercise the wrapping of the sums.

// File: rtl/arx_mix_core.sv
module arx_mix_core (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        busy,
  output logic        done,
  output logic [15:0] z0,
  output logic [15:0] z1,
  output logic [15:0] z2,
  output logic [15:0] z3
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CALC, S_XOR, S_SUM, S_DONE} st_t;

  st_t         state;
  logic [2:0]  wcnt;
  logic [1:0]  rcnt;
  logic [15:0] mem [0:7];
  logic [15:0] tx [0:3];
  logic [15:0] ty [0:3];
  logic [15:0] p [0:3];
  logic [15:0] q [0:3];
  logic [15:0] xs, ys, xr, yr;

  function automatic logic [15:0] rotl(input logic [15:0] v, input logic [3:0] n);
    logic [31:0] t;
    t = {v, v} << n;
    return t[31:16];
  endfunction

  always_comb begin
    case (rcnt)
      2'd0: begin
        xs = 16'hF0E8 + mem[0] + mem[1] + mem[2]; xr = rotl(xs, 4'd1);
        ys = 16'hD1CC + mem[4] + mem[6] + mem[7]; yr = rotl(ys, 4'd2);
      end
      2'd1: begin
        xs = 16'hE4E2 + mem[0] + mem[1] + mem[3]; xr = rotl(xs, 4'd4);
        ys = 16'hCAC9 + mem[5] + mem[6] + mem[7]; yr = rotl(ys, 4'd5);
      end
      2'd2: begin
        xs = 16'hE1D8 + mem[0] + mem[2] + mem[3]; xr = rotl(xs, 4'd9);
        ys = 16'hC6C5 + mem[4] + mem[5] + mem[6]; yr = rotl(ys, 4'd7);
      end
      default: begin
        xs = 16'hD4D2 + mem[1] + mem[2] + mem[3]; xr = rotl(xs, 4'd11);
        ys = 16'hC3B8 + mem[4] + mem[5] + mem[7]; yr = rotl(ys, 4'd13);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      wcnt  <= '0;
      rcnt  <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          state <= S_LOAD;
          wcnt  <= '0;
        end
        S_LOAD: if (in_valid) begin
          wcnt <= wcnt + 3'd1;
          if (wcnt == 3'd7) begin
            state <= S_CALC;
            rcnt  <= '0;
          end
        end
        S_CALC: begin
          rcnt <= rcnt + 2'd1;
          if (rcnt == 2'd3) state <= S_XOR;
        end
        S_XOR: state <= S_SUM;
        S_SUM: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid) mem[wcnt] <= in_word;
    if (state == S_CALC) begin
      tx[rcnt] <= xr;
      ty[rcnt] <= yr;
    end
    if (state == S_XOR) begin
      p[0] <= tx[0] ^ tx[1] ^ tx[3];
      p[1] <= tx[0] ^ tx[1] ^ tx[2];
      p[2] <= tx[1] ^ tx[2] ^ tx[3];
      p[3] <= tx[0] ^ tx[2] ^ tx[3];
      q[0] <= ty[1] ^ ty[2] ^ ty[3];
      q[1] <= ty[0] ^ ty[2] ^ ty[3];
      q[2] <= ty[0] ^ ty[1] ^ ty[3];
      q[3] <= ty[0] ^ ty[1] ^ ty[2];
    end
    if (state == S_SUM) begin
      z3 <= p[0] + q[0];
      z0 <= p[1] + q[1];
      z1 <= p[2] + q[2];
      z2 <= p[3] + q[3];
    end
  end

  assign busy = (state == S_LOAD) || (state == S_CALC) || (state == S_XOR) || (state == S_SUM);
  assign done = (state == S_DONE);

  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state) == S_SUM);
  assert_load_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && !in_valid) |=> $stable(wcnt));
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && start && !in_valid) |=> (state == S_LOAD && $stable(wcnt)));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start) |=> state == S_IDLE);
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  assert_z_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(z0) && $stable(z1) && $stable(z2) && $stable(z3)));
endmodule

// File: tb/tb_arx_mix_core.sv
module tb_arx_mix_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic busy, done;
  logic [15:0] z0, z1, z2, z3;

  always #10 clk = ~clk;

  arx_mix_core dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_word(in_word),
    .busy(busy), .done(done), .z0(z0), .z1(z1), .z2(z2), .z3(z3)
  );

  int checks = 0;
  int bad = 0;
  string cur_tag = "R8";

  logic [15:0] m_q [$];
  logic        m_busy = 1'b0;
  logic        m_done = 1'b0;
  int          m_cd = -1;
  logic [63:0] m_z = '0;

  function automatic int rot16(input int v, input int r);
    return ((v << r) | (v >> (16 - r))) & 32'hFFFF;
  endfunction

  function automatic logic [63:0] ref_z(input logic [15:0] w [0:7]);
    int kx [4] = '{32'hF0E8, 32'hE4E2, 32'hE1D8, 32'hD4D2};
    int rx [4] = '{1, 4, 9, 11};
    int sx [4] = '{3, 2, 1, 0};
    int ky [4] = '{32'hD1CC, 32'hCAC9, 32'hC6C5, 32'hC3B8};
    int ry [4] = '{2, 5, 7, 13};
    int sy [4] = '{1, 0, 3, 2};
    int dx [4] = '{2, 3, 0, 1};
    int t [4];
    int u [4];
    int zz [4];
    int allx = 0, ally = 0, sumx = 0, sumy = 0;
    for (int i = 0; i < 4; i++) begin
      sumx += int'(w[i]);
      sumy += int'(w[4+i]);
    end
    for (int i = 0; i < 4; i++) begin
      t[i] = rot16((kx[i] + sumx - int'(w[sx[i]])) & 32'hFFFF, rx[i]);
      u[i] = rot16((ky[i] + sumy - int'(w[4+sy[i]])) & 32'hFFFF, ry[i]);
      allx ^= t[i];
      ally ^= u[i];
    end
    for (int i = 0; i < 4; i++)
      zz[(i + 3) % 4] = ((allx ^ t[dx[i]]) + (ally ^ u[i])) & 32'hFFFF;
    return {zz[3][15:0], zz[2][15:0], zz[1][15:0], zz[0][15:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_cd = -1; m_q.delete();
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1'b1; m_done = 1'b0; m_cd = -1; m_q.delete();
      end
    end else if (m_q.size() < 8) begin
      if (in_valid) begin
        m_q.push_back(in_word);
        if (m_q.size() == 8) m_cd = 6;
      end
    end else begin
      m_cd--;
      if (m_cd == 0) begin
        logic [15:0] w [0:7];
        for (int i = 0; i < 8; i++) w[i] = m_q[i];
        m_z = ref_z(w);
        m_busy = 1'b0;
        m_done = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(busy === m_busy, "R5", 64'(busy), 64'(m_busy));
      check(done === m_done, "R9", 64'(done), 64'(m_done));
      if (m_done) check({z3, z2, z1, z0} === m_z, cur_tag, {z3, z2, z1, z0}, m_z);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic run(input string tag, input logic [15:0] w [0:7], input int gap, input bit stray_start);
    cur_tag = tag;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_word = w[i];
      @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0; in_word = 16'hDEAD;
        if (stray_start && i == 3 && g == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    in_valid = 1'b1; in_word = 16'hBEEF;
    if (stray_start) start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!m_done) @(negedge clk);
    in_valid = 1'b1; in_word = 16'h1234;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] w [0:7];
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check(busy === 1'b0, "R1", 64'(busy), 64'd0);
    check(done === 1'b0, "R1", 64'(done), 64'd0);
    rst = 1'b0;
    // R3: strobes while idle do nothing
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_word = 16'(i * 7 + 1);
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0, "R3", {busy, done}, 64'd0);
    end
    in_valid = 1'b0;
    w = '{16'h0123, 16'h4567, 16'h89AB, 16'hCDEF, 16'h0, 16'h0, 16'h0, 16'h0};
    run("R6", w, 0, 1'b0);
    w = '{16'h0, 16'h0, 16'h0, 16'h0, 16'hA5A5, 16'h5A5A, 16'h1357, 16'h2468};
    run("R7", w, 0, 1'b0);
    w = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    run("R8", w, 0, 1'b0);
    w = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888};
    run("R2", w, 2, 1'b0);
    w = '{16'hC001, 16'h0FF1, 16'hBADD, 16'hF00D, 16'h7E57, 16'h0042, 16'h9999, 16'h3C3C};
    run("R4", w, 1, 1'b1);
    // R9: result held while idle strobes arrive
    in_valid = 1'b1; in_word = 16'hFFFF;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    check(done === 1'b1, "R9", 64'(done), 64'd1);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) w[i] = 16'((k * 40503 + i * 9973 + 17) & 16'hFFFF);
      run("R8", w, k % 3, k[0]);
    end
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule